// File: doc/BRIEF.md
# Wake-up External Interrupt Controller

The block watches 28 external wake-up lines. Each line has a programmable trigger condition: low level, high level, falling edge, rising edge or both edges. When the condition is met, the line's bit in a pending register is set. Pending bits are combined with a per-line mask and reduced into four parent interrupt outputs. These outputs cover groups of unequal size: lines 0-3, 4-11, 12-19 and 20-27.

Software reaches the block through a single-cycle 32-bit register port that offers write and combinational read. It sets the trigger fields, the mask and the pending bits, and it clears pending bits by writing ones. Adjacent lines share one 4-bit trigger field, so lines 2k and 2k+1 always use the same condition.

The raw lines pass through a parameterised flop synchronizer. After reset, a two-state sequencer holds detection off until the synchronizer and the previous-sample flops carry real pin values. In the FILL state, detection is off and the sequencer counts SYNC_STAGES+1 cycles. The FILL to LIVE transition is taken when the count ends. LIVE is then held until the next reset.

Top module: `wkint_ctrl`

## Requirements
- R1: After reset every line is masked (mask word reads 0x0FFFFFFF), every pending bit is 0, every trigger field is 0 and all four parent outputs are 0.
- R2: The trigger field of line n is bits 4*(n/2)+3..4*(n/2) of the word at offset 0x00 when n < 16. When n >= 16, it is bits 4*((n-16)/2)+3..4*((n-16)/2) of the word at offset 0x04. Lines 2k and 2k+1 share one field.
- R3: Code 0 sets pending while the line is low, and code 1 sets it while the line is high. While the level persists, a pending bit that is cleared is set again.
- R4: Code 2 sets pending on a high-to-low change, code 4 on a low-to-high change and code 6 on either change. Each change is judged against the previous synchronized sample.
- R5: Any other trigger code (3, 5, 7, 8-15) never sets pending.
- R6: Mask word at offset 0x20: bit n = 1 masks line n and 0 unmasks it. A masked line still records pending, and masking only gates the parent outputs.
- R7: Pending word at offset 0x24: writing 1 to bit n clears it, and writing 0 leaves it unchanged. If a trigger hit coincides with a clear, the set wins.
- R8: Parent output g (bit g of irq_grp) is 1 while any line in its range has pending set and mask clear. The ranges are 0-3 for g=0, 4-11 for g=1, 12-19 for g=2 and 20-27 for g=3.
- R9: Unimplemented bits read 0: bits 31:24 at offset 0x04, bits 31:28 of mask and pending, and every other offset.
- R10: A line change takes effect after SYNC_STAGES synchronizer flops. No pending bit can be set during the FILL state after reset, and a level already present at reset is recorded once LIVE is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 28 | External wake-up lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_grp | output | 4 | Parent interrupt outputs, one per line group |

## Verification
The bench goes after the group boundaries (lines 3/4, 11/12, 19/20 and 27). A design that put a boundary in the wrong place would raise the wrong parent output. It also checks the shared trigger field of a pair and the split of line numbers across the two config words. A wrong field index would arm the neighbour of the intended line or a line in the other word.

Level triggers are checked for re-assertion after a clear, and edge triggers are checked to fire only on the stated transition. A design that treated a level as an edge would leave pending cleared. One that took the raw pin instead of the previous sample would miss transitions or fire on steady lines.

The bench also checks that writing zeros to pending clears nothing, that unknown codes stay silent, and that a low level held through reset is recorded only after the fill phase.

// File: rtl/wkint_pkg.sv
package wkint_pkg;

    typedef enum logic [3:0] {
        TRG_LOW  = 4'd0,
        TRG_HIGH = 4'd1,
        TRG_FALL = 4'd2,
        TRG_RISE = 4'd4,
        TRG_BOTH = 4'd6
    } trig_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_LIVE = 1'b1
    } phase_e;

    function automatic logic code_known(input logic [3:0] code);
        case (code)
            TRG_LOW, TRG_HIGH, TRG_FALL, TRG_RISE, TRG_BOTH: code_known = 1'b1;
            default:                                        code_known = 1'b0;
        endcase
    endfunction

    function automatic logic trig_hit(input logic [3:0] code,
                                      input logic cur, input logic old);
        case (code)
            TRG_LOW:  trig_hit = ~cur;
            TRG_HIGH: trig_hit = cur;
            TRG_FALL: trig_hit = old & ~cur;
            TRG_RISE: trig_hit = ~old & cur;
            TRG_BOTH: trig_hit = old ^ cur;
            default:  trig_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wkint_sync.sv
module wkint_sync #(
    parameter int WIDTH  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d_in;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign d_out = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/wkint_detect.sv
module wkint_detect
    import wkint_pkg::*;
#(
    parameter int LINES       = 28,
    parameter int SYNC_STAGES = 2,
    localparam int FIELDS     = (LINES + 1) / 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LINES-1:0]      cur,
    input  logic [4*FIELDS-1:0]   fld,
    input  logic [LINES-1:0]      clr,
    output logic [LINES-1:0]      pend
);
    localparam int FILL = SYNC_STAGES + 1;
    localparam int CW   = $clog2(FILL + 1);

    phase_e          st_q, st_nx;
    logic [CW-1:0]   cnt_q;
    logic            live;
    logic [LINES-1:0] prev_q, hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FILL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            if (st_q == ST_FILL) cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_FILL: st_nx = (cnt_q == CW'(FILL - 1)) ? ST_LIVE : ST_FILL;
            ST_LIVE: st_nx = ST_LIVE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        live = 1'b0;
        unique case (st_q)
            ST_FILL: live = 1'b0;
            ST_LIVE: live = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= cur;
            pend   <= (pend & ~clr) | hit;
        end
    end

    genvar n;
    generate
        for (n = 0; n < LINES; n++) begin : g_line
            logic [3:0] code;
            assign code   = fld[4*(n/2) +: 4];
            assign hit[n] = live & trig_hit(code, cur[n], prev_q[n]);

            // R5
            code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend[n]) |-> $past(code_known(code)));
        end
    endgenerate

    // R10
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL) |=> (pend == '0));

endmodule

// File: rtl/wkint_regs.sv
module wkint_regs #(
    parameter int LINES        = 28,
    parameter int MASK_OFFSET  = 32'h20,
    parameter int PEND_OFFSET  = 32'h24,
    localparam int FIELDS      = (LINES + 1) / 2,
    localparam int CFG_WORDS   = (FIELDS + 7) / 8,
    localparam int MASK_IDX    = MASK_OFFSET / 4,
    localparam int PEND_IDX    = PEND_OFFSET / 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [5:0]          addr,
    input  logic [31:0]         wdata,
    input  logic [LINES-1:0]    pend,
    output logic [31:0]         rdata,
    output logic [4*FIELDS-1:0] fld,
    output logic [LINES-1:0]    mask,
    output logic [LINES-1:0]    clr
);
    logic [3:0]  idx;
    logic [31:0] cfg_word [CFG_WORDS];

    assign idx = addr[5:2];

    genvar f;
    generate
        for (f = 0; f < FIELDS; f++) begin : g_fld
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    fld[4*f +: 4] <= 4'd0;
                else if (we && idx == 4'(f / 8))
                    fld[4*f +: 4] <= wdata[4*(f % 8) +: 4];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '1;
        else if (we && idx == 4'(MASK_IDX))
            mask <= wdata[LINES-1:0];
    end

    assign clr = (we && idx == 4'(PEND_IDX)) ? wdata[LINES-1:0] : '0;

    always_comb begin
        for (int w = 0; w < CFG_WORDS; w++) cfg_word[w] = '0;
        for (int k = 0; k < FIELDS; k++) cfg_word[k / 8][4*(k % 8) +: 4] = fld[4*k +: 4];
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < CFG_WORDS; w++)
            if (idx == 4'(w)) rdata = cfg_word[w];
        if (idx == 4'(MASK_IDX)) rdata = 32'(mask);
        if (idx == 4'(PEND_IDX)) rdata = 32'(pend);
    end

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && idx == 4'(MASK_IDX)) |=> $stable(mask));

endmodule

// File: rtl/wkint_ctrl.sv
module wkint_ctrl #(
    parameter int LINES       = 28,
    parameter int SYNC_STAGES = 2,
    parameter int FIRST_GRP   = 4,
    parameter int GRP_LINES   = 8,
    parameter int GROUPS      = 4,
    localparam int FIELDS     = (LINES + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  line_in,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [GROUPS-1:0] irq_grp
);
    logic [LINES-1:0]    cur, pend, mask, clr, act;
    logic [4*FIELDS-1:0] fld;

    wkint_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(line_in), .d_out(cur)
    );

    wkint_detect #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk(clk), .rst_n(rst_n), .cur(cur), .fld(fld), .clr(clr), .pend(pend)
    );

    wkint_regs #(.LINES(LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .pend(pend), .rdata(reg_rdata), .fld(fld), .mask(mask), .clr(clr)
    );

    assign act = pend & ~mask;

    genvar g;
    generate
        for (g = 0; g < GROUPS; g++) begin : g_grp
            localparam int LO = (g == 0) ? 0 : FIRST_GRP + (g - 1) * GRP_LINES;
            localparam int W  = (g == 0) ? FIRST_GRP : GRP_LINES;
            assign irq_grp[g] = |act[LO +: W];
        end
    endgenerate

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_grp != '0) |-> ((pend & ~mask) != '0));

endmodule

// File: tb/wkint_ctrl_tb.sv
module wkint_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] lines = 28'h7FFFFFF;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_grp;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wkint_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(lines), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_grp(irq_grp)
    );

    typedef struct packed {
        logic [4:0] line;
        logic [3:0] trig;
        logic [1:0] stim;   // 0 none, 1 drive low and hold, 2 low pulse
        logic       exp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{5'd0,  4'd0, 2'd1, 1'b1},
        '{5'd3,  4'd0, 2'd0, 1'b0},
        '{5'd4,  4'd1, 2'd0, 1'b1},
        '{5'd11, 4'd2, 2'd1, 1'b1},
        '{5'd12, 4'd2, 2'd0, 1'b0},
        '{5'd19, 4'd4, 2'd1, 1'b0},
        '{5'd20, 4'd4, 2'd2, 1'b1},
        '{5'd27, 4'd6, 2'd1, 1'b1},
        '{5'd15, 4'd6, 2'd2, 1'b1},
        '{5'd16, 4'd3, 2'd1, 1'b0},
        '{5'd9,  4'd8, 2'd2, 1'b0},
        '{5'd22, 4'd1, 2'd2, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_field(input int line, input logic [3:0] code);
        logic [31:0] w;
        logic [5:0]  a;
        int          sh;
        a  = (line < 16) ? 6'h00 : 6'h04;
        sh = 4 * ((line % 16) / 2);
        rd(a, w);
        w[sh +: 4] = code;
        wr(a, w);
    endtask

    function automatic int grp_of(input int line);
        if (line < 4) return 0;
        if (line < 12) return 1;
        if (line < 20) return 2;
        return 3;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        lines[27] = 1'b0;
        idle(3);
        rst_n = 1'b1;
        // R1 reset state, read before fill completes
        rd(6'h24, d); chk("R1 pend", d, 32'h0);
        chk("R1 irq", 32'(irq_grp), 32'h0);
        rd(6'h20, d); chk("R1 mask", d, 32'h0FFFFFFF);
        rd(6'h00, d); chk("R1 cfg0", d, 32'h0);
        rd(6'h04, d); chk("R1 cfg1", d, 32'h0);
        // R10 level held through reset recorded after fill; R6 masked still records
        idle(8);
        rd(6'h24, d); chk("R10 level after fill", d, 32'h08000000);
        chk("R6 masked no irq", 32'(irq_grp), 32'h0);
        lines[27] = 1'b1;
        wr(6'h00, 32'h22222222);
        wr(6'h04, 32'h00222222);
        idle(6);
        wr(6'h24, 32'h0FFFFFFF);
        idle(2);
        rd(6'h24, d); chk("R7 clear all", d, 32'h0);

        // vector table walk: R2 R3 R4 R5 R8
        for (int i = 0; i < 12; i++) begin
            int ln;
            ln = int'(VEC[i].line);
            set_field(ln, VEC[i].trig);
            idle(2);
            wr(6'h24, 32'h0FFFFFFF);
            wr(6'h20, 32'h0FFFFFFF & ~(32'h1 << ln));
            if (VEC[i].stim == 2'd1) lines[ln] = 1'b0;
            if (VEC[i].stim == 2'd2) begin
                lines[ln] = 1'b0; idle(6); lines[ln] = 1'b1;
            end
            idle(8);
            rd(6'h24, d);
            chk($sformatf("R3/R4/R5 vec%0d line%0d pend", i, ln), 32'(d[ln]), 32'(VEC[i].exp));
            chk($sformatf("R8 vec%0d irq", i), 32'(irq_grp),
                VEC[i].exp ? (32'h1 << grp_of(ln)) : 32'h0);
            wr(6'h20, 32'h0FFFFFFF);
            lines[ln] = 1'b1;
            idle(8);
            set_field(ln, 4'd2);
            idle(2);
            wr(6'h24, 32'h0FFFFFFF);
            idle(2);
        end

        // R3 level re-asserts after clear
        set_field(8, 4'd0);
        lines[8] = 1'b0;
        idle(8);
        wr(6'h24, 32'h00000100);
        idle(1);
        rd(6'h24, d); chk("R3 reassert", 32'(d[8]), 32'h1);
        lines[8] = 1'b1;
        idle(6);
        set_field(8, 4'd2);
        wr(6'h24, 32'h0FFFFFFF);

        // R7 writing zero leaves bit set
        lines[5] = 1'b0; idle(6); lines[5] = 1'b1; idle(6);
        wr(6'h24, 32'hFFFFFFDF);
        rd(6'h24, d); chk("R7 zero keeps", d, 32'h00000020);
        wr(6'h24, 32'h00000020);
        rd(6'h24, d); chk("R7 one clears", d, 32'h0);

        // R2 shared pair and second word position
        wr(6'h04, 32'h00222224);
        lines[17] = 1'b0; lines[18] = 1'b0;
        idle(8);
        rd(6'h24, d); chk("R2 word1 fields", d & 32'h00070000, 32'h00040000);
        lines[17] = 1'b1; lines[18] = 1'b1;
        idle(8);
        rd(6'h24, d); chk("R2 pair 16/17 rise", d & 32'h00030000, 32'h00020000);
        wr(6'h04, 32'h00222222);
        wr(6'h24, 32'h0FFFFFFF);
        wr(6'h00, 32'h22224222);
        lines[6] = 1'b0; lines[7] = 1'b0; idle(6);
        lines[6] = 1'b1; lines[7] = 1'b1; idle(6);
        rd(6'h24, d); chk("R2 pair 6/7 shared", d, 32'h000000C0);
        wr(6'h00, 32'h22222222);
        wr(6'h24, 32'h0FFFFFFF);

        // R8 two groups at once
        lines[3] = 1'b0; lines[12] = 1'b0; idle(6);
        wr(6'h20, 32'h0FFFEFF7);
        idle(1);
        chk("R8 two groups", 32'(irq_grp), 32'h5);
        wr(6'h20, 32'h0FFFFFFF);
        chk("R6 remask gates", 32'(irq_grp), 32'h0);
        lines[3] = 1'b1; lines[12] = 1'b1;
        wr(6'h24, 32'h0FFFFFFF);

        // R9 unused bits
        wr(6'h04, 32'hFFFFFFFF);
        rd(6'h04, d); chk("R9 cfg1 upper", d, 32'h00FFFFFF);
        rd(6'h10, d); chk("R9 hole", d, 32'h0);
        wr(6'h20, 32'hFFFFFFFF);
        rd(6'h20, d); chk("R9 mask upper", d, 32'h0FFFFFFF);
        // R5 codes 15 never fire, even on toggles
        lines[20] = 1'b0; idle(6); lines[20] = 1'b1; idle(6);
        rd(6'h24, d); chk("R5 code15 silent", d, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule